// File: doc/BRIEF.md
# Incrementing-Pattern RAM Scanner

This block is a built-in self-test engine for a byte-wide synchronous RAM that sits outside it. After a start pulse it runs an endless series of scans over a parameterised address window. Each scan is built from three steps:

- a fill pass, which stores one test byte at every address of the window;
- a check pass, which reads every address back and compares it with that byte;
- a one-cycle settle step, which compares the last read.

The test byte then steps up by one and the next scan begins. The scanner keeps going until a read-back mismatch or a stop request. A mismatch halts it and exposes the failing address. A stop ends the run quietly.

The RAM port issues one access in every cycle of a pass. It has no valid/ready handshake, so the memory must accept an access every cycle and return read data exactly one clock after the address. The start, stop, progress and error pins are plain levels or pulses. A progress pulse marks every 256 completed scans, so software or a front panel can see that a long run is still alive.

Top module: `ram_pattern_scanner`

## Requirements
- R1: Both passes visit the addresses WIN_LO to WIN_HI (parameters) in ascending order. Each address is visited exactly once per pass, and `ram_addr_o` never leaves the window.
- R2: In each scan, every address of the window is written (`ram_we_o`=1) before any read of that scan. A scan lasts 2N+1 cycles: N write cycles, then N read cycles, then one settle cycle, where N = WIN_HI-WIN_LO+1.
- R3: Read data is taken one clock after its address was issued and is compared with the test byte of the current scan. A correct memory never raises `err_o`.
- R4: The first scan after start writes byte 0x00. The byte rises by one for each new scan and wraps from 0xFF to 0x00.
- R5: `tick_o` is high for exactly one cycle, on the first write cycle that follows the completion of scan 256, 512, 768 and so on. It is low in all other cycles.
- R6: On a mismatch, `err_o` rises two clocks after the failing address was driven, and `err_addr_o` shows that address. From then on there are no writes and `ram_addr_o` is frozen. Both outputs hold until the next start.
- R7: A stop pulse in any running cycle ends the test without raising `err_o`, even in the cycle where a mismatch is being compared. After a stop, no writes occur and the address is frozen. A stop while halted on an error leaves the error in place.
- R8: A start pulse from any state clears the error and restarts from scan 0 at WIN_LO, with the first write in the cycle after start. Start wins over a simultaneous stop.
- R9: During and after reset, `err_o`, `tick_o` and `ram_we_o` are 0 and the block is idle until a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start or restart pulse |
| stop_i | input | 1 | Abort request |
| ram_addr_o | output | AW | RAM address |
| ram_wdata_o | output | DW | RAM write data (current test byte) |
| ram_we_o | output | 1 | RAM write enable |
| ram_rdata_i | input | DW | RAM read data, one clock after address |
| tick_o | output | 1 | One-cycle pulse every 256 completed scans |
| err_o | output | 1 | Mismatch found, held |
| err_addr_o | output | AW | Address of the first mismatch |

## Verification
An eight-address window is swept through 600 clean scans. This covers the byte wrap and two progress pulses, and every write and read address and every write byte is compared against an arithmetic model of the sequence. Three fault patterns are then tried, and each separates a different timing path:
- a bit flip at an interior address checks the one-clock compare alignment;
- a flip at the last address checks the settle-step compare;
- a stuck-at-zero bit that only shows once the test byte has that bit set checks that the byte really changes from scan to scan.

Stops are placed in the write pass, in the read pass and on the exact mismatch cycle. A start is also given together with a stop.

// File: rtl/ram_scan_pkg.sv
package ram_scan_pkg;
  typedef enum logic [2:0] {
    SC_IDLE   = 3'd0,
    SC_FILL   = 3'd1,
    SC_CHECK  = 3'd2,
    SC_SETTLE = 3'd3,
    SC_HALT   = 3'd4
  } scan_state_e;
endpackage

// File: rtl/scan_addr_gen.sv
module scan_addr_gen #(
  parameter int AW = 16,
  parameter logic [AW-1:0] WIN_LO = 16'h0040,
  parameter logic [AW-1:0] WIN_HI = 16'h9FFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_lo,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic          at_hi
);
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= WIN_LO;
    else if (load_lo) addr_q <= WIN_LO;
    else if (step)    addr_q <= addr_q + 1'b1;
  end

  assign addr  = addr_q;
  assign at_hi = (addr_q == WIN_HI);

  AST_ADDR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_q >= WIN_LO) && (addr_q <= WIN_HI)); // R1
  AST_STEP_BELOW_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load_lo) |-> (addr_q != WIN_HI)); // R1
endmodule

// File: rtl/scan_pattern.sv
module scan_pattern #(
  parameter int DW        = 8,
  parameter int TICK_LOG2 = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          advance,
  output logic [DW-1:0] pattern,
  output logic          tick
);
  logic [DW-1:0]        pattern_q;
  logic [TICK_LOG2-1:0] scan_cnt_q;
  logic                 tick_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pattern_q  <= '0;
      scan_cnt_q <= '0;
      tick_q     <= 1'b0;
    end else if (clear) begin
      pattern_q  <= '0;
      scan_cnt_q <= '0;
      tick_q     <= 1'b0;
    end else if (advance) begin
      pattern_q  <= pattern_q + 1'b1;
      scan_cnt_q <= scan_cnt_q + 1'b1;
      tick_q     <= &scan_cnt_q;
    end else begin
      tick_q     <= 1'b0;
    end
  end

  assign pattern = pattern_q;
  assign tick    = tick_q;

  AST_PATTERN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !clear) |=> $stable(pattern_q)); // R3
  AST_PATTERN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !clear) |=> (pattern_q == $past(pattern_q) + 1'b1)); // R4
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |=> !tick_q); // R5
endmodule

// File: rtl/scan_compare.sv
module scan_compare #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic [AW-1:0] issue_addr,
  input  logic [DW-1:0] rdata,
  input  logic [DW-1:0] expected,
  output logic          miss,
  output logic [AW-1:0] miss_addr
);
  logic          pend_q;
  logic [AW-1:0] pend_addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
    end else begin
      pend_q <= issue;
      if (issue) pend_addr_q <= issue_addr;
    end
  end

  assign miss      = pend_q && (rdata != expected);
  assign miss_addr = pend_addr_q;

  AST_MISS_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> $past(issue)); // R3
endmodule

// File: rtl/ram_pattern_scanner.sv
module ram_pattern_scanner
  import ram_scan_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int TICK_LOG2 = 8,
  parameter logic [AW-1:0] WIN_LO = 16'h0040,
  parameter logic [AW-1:0] WIN_HI = 16'h9FFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          stop_i,
  output logic [AW-1:0] ram_addr_o,
  output logic [DW-1:0] ram_wdata_o,
  output logic          ram_we_o,
  input  logic [DW-1:0] ram_rdata_i,
  output logic          tick_o,
  output logic          err_o,
  output logic [AW-1:0] err_addr_o
);
  scan_state_e   state_q, state_d;
  logic          load_lo, step, at_hi;
  logic [AW-1:0] addr;
  logic          issue, miss;
  logic [AW-1:0] miss_addr;
  logic          clear_pat, advance;
  logic [DW-1:0] pattern;
  logic          running, do_stop;
  logic          err_q;
  logic [AW-1:0] err_addr_q;

  assign running = (state_q == SC_FILL) || (state_q == SC_CHECK) || (state_q == SC_SETTLE);
  assign do_stop = stop_i && !start_i && running;

  always_comb begin
    state_d   = state_q;
    load_lo   = 1'b0;
    step      = 1'b0;
    issue     = 1'b0;
    advance   = 1'b0;
    clear_pat = 1'b0;
    if (start_i) begin
      state_d   = SC_FILL;
      load_lo   = 1'b1;
      clear_pat = 1'b1;
    end else if (do_stop) begin
      state_d = SC_IDLE;
    end else if (miss) begin
      state_d = SC_HALT;
    end else begin
      case (state_q)
        SC_FILL: begin
          if (at_hi) begin
            load_lo = 1'b1;
            state_d = SC_CHECK;
          end else begin
            step = 1'b1;
          end
        end
        SC_CHECK: begin
          issue = 1'b1;
          if (at_hi) state_d = SC_SETTLE;
          else       step    = 1'b1;
        end
        SC_SETTLE: begin
          load_lo = 1'b1;
          advance = 1'b1;
          state_d = SC_FILL;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SC_IDLE;
      err_q      <= 1'b0;
      err_addr_q <= '0;
    end else begin
      state_q <= state_d;
      if (start_i) begin
        err_q <= 1'b0;
      end else if (state_q != SC_HALT && state_d == SC_HALT) begin
        err_q      <= 1'b1;
        err_addr_q <= miss_addr;
      end
    end
  end

  scan_addr_gen #(.AW(AW), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_addr (
    .clk(clk), .rst_n(rst_n), .load_lo(load_lo), .step(step),
    .addr(addr), .at_hi(at_hi)
  );

  scan_pattern #(.DW(DW), .TICK_LOG2(TICK_LOG2)) u_pat (
    .clk(clk), .rst_n(rst_n), .clear(clear_pat), .advance(advance),
    .pattern(pattern), .tick(tick_o)
  );

  scan_compare #(.AW(AW), .DW(DW)) u_cmp (
    .clk(clk), .rst_n(rst_n), .issue(issue), .issue_addr(addr),
    .rdata(ram_rdata_i), .expected(pattern),
    .miss(miss), .miss_addr(miss_addr)
  );

  assign ram_addr_o  = addr;
  assign ram_wdata_o = pattern;
  assign ram_we_o    = (state_q == SC_FILL);
  assign err_o       = err_q;
  assign err_addr_o  = err_addr_q;

  AST_FILL_FROM_LO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_we_o) |-> (ram_addr_o == WIN_LO)); // R2
  AST_ERR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !start_i) |=> (err_q && $stable(err_addr_q) && !ram_we_o && $stable(ram_addr_o))); // R6
  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !start_i && !err_q) |=> !err_q); // R7
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!err_q && ram_we_o && ram_addr_o == WIN_LO)); // R8
  AST_ERR_ADDR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> ((err_addr_q >= WIN_LO) && (err_addr_q <= WIN_HI))); // R1
endmodule

// File: tb/tb_ram_pattern_scanner.sv
`timescale 1ns/1ps
module tb_ram_pattern_scanner;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam logic [AW-1:0] LO = 16'd4;
  localparam logic [AW-1:0] HI = 16'd11;
  localparam int N    = 8;
  localparam int SCAN = 2*N + 1;

  logic clk, rst_n, start_i, stop_i;
  logic [AW-1:0] ram_addr_o, err_addr_o;
  logic [DW-1:0] ram_wdata_o, ram_rdata_i;
  logic ram_we_o, tick_o, err_o;

  ram_pattern_scanner #(.AW(AW), .DW(DW), .TICK_LOG2(8), .WIN_LO(LO), .WIN_HI(HI)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .ram_addr_o(ram_addr_o), .ram_wdata_o(ram_wdata_o), .ram_we_o(ram_we_o),
    .ram_rdata_i(ram_rdata_i), .tick_o(tick_o), .err_o(err_o), .err_addr_o(err_addr_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // RAM model with one-clock read latency and a read-side fault injector
  logic [DW-1:0] mem [0:15];
  logic [AW-1:0] fault_addr;
  logic [DW-1:0] fault_and, fault_xor;
  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 8'hAA;
    ram_rdata_i = '0;
  end
  always @(posedge clk) begin
    logic [DW-1:0] rd;
    rd = mem[ram_addr_o[3:0]];
    if (ram_addr_o == fault_addr) rd = (rd & fault_and) ^ fault_xor;
    if (ram_we_o) mem[ram_addr_o[3:0]] <= ram_wdata_o;
    ram_rdata_i <= rd;
  end

  int nchk = 0, nerr = 0;
  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Arithmetic model of the scan sequence
  int ph, ea, eb, done_scans, ticks;
  bit due;
  int e_wr, e_addr, e_byte, e_tick, e_err;
  task automatic mon_reset();
    ph = 0; ea = LO; eb = 0; done_scans = 0; due = 0; ticks = 0;
    e_wr = 0; e_addr = 0; e_byte = 0; e_tick = 0; e_err = 0;
  endtask
  task automatic run_mon(input int cyc);
    repeat (cyc) begin
      bit exp_tick;
      @(negedge clk);
      exp_tick = 1'b0;
      case (ph)
        0: begin
          if (!ram_we_o) e_wr++;
          if (ram_addr_o != ea) e_addr++;
          if (ram_wdata_o != eb[7:0]) e_byte++;
          exp_tick = due; due = 0;
          if (ea == HI) begin ea = LO; ph = 1; end else ea++;
        end
        1: begin
          if (ram_we_o) e_wr++;
          if (ram_addr_o != ea) e_addr++;
          if (ea == HI) ph = 2; else ea++;
        end
        default: begin
          if (ram_we_o) e_wr++;
          ph = 0; ea = LO; eb = (eb + 1) % 256; done_scans++;
          due = (done_scans % 256 == 0);
        end
      endcase
      if (tick_o != exp_tick) e_tick++;
      if (tick_o) ticks++;
      if (err_o) e_err++;
    end
  endtask
  task automatic mon_report(input string ctx);
    chk(e_addr == 0, {"R1 address order ", ctx}, e_addr, 0);
    chk(e_wr == 0,   {"R2 fill before check ", ctx}, e_wr, 0);
    chk(e_err == 0,  {"R3 no false mismatch ", ctx}, e_err, 0);
    chk(e_byte == 0, {"R4 test byte ", ctx}, e_byte, 0);
    chk(e_tick == 0, {"R5 tick placement ", ctx}, e_tick, 0);
  endtask

  task automatic do_start(input bit with_stop);
    @(negedge clk);
    start_i = 1'b1; stop_i = with_stop;
    @(posedge clk); #1;
    start_i = 1'b0; stop_i = 1'b0;
  endtask
  task automatic pulse_stop();
    stop_i = 1'b1;
    @(posedge clk); #1;
    stop_i = 1'b0;
  endtask
  task automatic wait_err(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!err_o && n < 2000);
  endtask
  task automatic check_quiet(input string tag, input int cyc, input bit exp_err);
    int wr = 0, mv = 0, ebad = 0;
    logic [AW-1:0] a0;
    @(negedge clk); a0 = ram_addr_o;
    repeat (cyc) begin
      @(negedge clk);
      if (ram_we_o) wr++;
      if (ram_addr_o != a0) mv++;
      if (err_o != exp_err) ebad++;
    end
    chk(wr == 0,   {tag, " no writes"}, wr, 0);
    chk(mv == 0,   {tag, " address frozen"}, mv, 0);
    chk(ebad == 0, {tag, " error flag"}, ebad, 0);
  endtask

  initial begin
    #(200000 * 10);
    nerr++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    int n;
    int wr;
    rst_n = 1'b0; start_i = 1'b0; stop_i = 1'b0;
    fault_addr = 16'hFFFF; fault_and = 8'hFF; fault_xor = 8'h00;
    repeat (3) @(negedge clk);
    chk(err_o == 0,    "R9 reset err", err_o, 0);
    chk(tick_o == 0,   "R9 reset tick", tick_o, 0);
    chk(ram_we_o == 0, "R9 reset we", ram_we_o, 0);
    rst_n = 1'b1;
    wr = 0;
    repeat (10) begin @(negedge clk); if (ram_we_o || err_o) wr++; end
    chk(wr == 0, "R9 idle after reset", wr, 0);

    // Long clean run: wrap and two progress ticks
    do_start(1'b0); mon_reset();
    run_mon(600 * SCAN);
    mon_report("long run");
    chk(ticks == 2, "R5 tick count over 600 scans", ticks, 2);

    // Stop during the write pass
    run_mon(3);
    pulse_stop();
    check_quiet("R7 stop in fill", 30, 1'b0);

    // Start together with stop restarts from scan 0
    do_start(1'b1); mon_reset();
    run_mon(3 * SCAN);
    mon_report("R8 restart with stop");

    // Stop during the read pass
    run_mon(N + 2);
    pulse_stop();
    check_quiet("R7 stop in check", 30, 1'b0);

    // Flip at an interior address
    fault_addr = 16'd7; fault_xor = 8'h10;
    do_start(1'b0); wait_err(n);
    chk(n == N + 3 + 3, "R6 interior miss latency", n, N + 6);
    chk(err_addr_o == 16'd7, "R6 interior miss address", err_addr_o, 7);
    check_quiet("R6 halted hold", 20, 1'b1);
    pulse_stop();
    check_quiet("R7 stop while halted", 10, 1'b1);

    // Start clears error and a clean memory runs
    fault_addr = 16'hFFFF; fault_xor = 8'h00;
    do_start(1'b0);
    @(negedge clk);
    chk(err_o == 0, "R8 start clears error", err_o, 0);
    chk(ram_addr_o == LO && ram_we_o && ram_wdata_o == 0, "R8 restart at LO byte 0", ram_addr_o, LO);
    mon_reset(); ph = 0; ea = LO + 1; run_mon(2 * SCAN - 1);
    mon_report("R8 after clear");

    // Flip at the last address (settle-step compare)
    fault_addr = HI; fault_xor = 8'h01;
    do_start(1'b0); wait_err(n);
    chk(n == 2 * N + 2, "R6 last-address miss latency", n, 2 * N + 2);
    chk(err_addr_o == HI, "R6 last-address miss address", err_addr_o, HI);

    // Stuck-at-zero bit 2 at address 5: first fails with byte 0x04 in scan 4
    fault_addr = 16'd5; fault_xor = 8'h00; fault_and = 8'hFB;
    do_start(1'b0); wait_err(n);
    chk(n == 4 * SCAN + N + 3 + 1, "R4 data-dependent miss scan", n, 4 * SCAN + N + 4);
    chk(err_addr_o == 16'd5, "R6 stuck-bit address", err_addr_o, 5);

    // Stop on the very cycle the mismatch is compared
    fault_addr = 16'd6; fault_and = 8'hFF; fault_xor = 8'h80;
    do_start(1'b0);
    repeat (N + 2 + 2) @(negedge clk);
    pulse_stop();
    check_quiet("R7 stop beats mismatch", 20, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule